// File: doc/BRIEF.md
# Seconds Real-Time Counter with Subsecond Alarms

This block keeps time from a 32.768 kHz timebase. The timebase reaches the block as a one-cycle enable, `tbEn`, on the block's own clock. Every eighth enabled cycle advances a 12-bit fraction counter, so each fraction step is 1/4096 s. Each wrap of the fraction counter advances a 32-bit count of whole seconds, which covers about 136 years. A signed trim value corrects the rate in steps of 1 ppm. It does this by adding or removing one timebase step at evenly spaced points.

The block has two alarms, and each sets a sticky flag.

- **Seconds-match alarm.** It fires when the seconds count reaches a programmed compare value. Any future second can be chosen. The interval register is wide enough for about 12 days. In recurring mode, the alarm moves its compare value forward by a programmed interval each time it fires.
- **Fraction countdown alarm.** It fires after a programmed number of 1/4096 s steps, from 1 up to 4096. In recurring mode, it reloads that number each time it fires.

Software sets the time, programs the alarms, sets the trim and clears the flags through a simple write port and a combinational read port. The flags drive two interrupt outputs and one combined wake request.

Top module: `rtc_top`

## Requirements
- R1: After reset the seconds count, fraction count and both flags are 0 and all three request outputs are low. While `tbEn` is low, neither count moves.
- R2: With trim 0, the fraction count (read address 1) advances once per 8 enabled timebase cycles. It wraps from 4095 to 0, and on that wrap the seconds count (read address 0) increments.
- R3: The seconds count is 32 bits wide and rolls over from 0xFFFFFFFF to 0.
- R4: A write to address 0 does not change the seconds count at once. At the next enabled timebase cycle, the seconds count takes the written value and the fraction count and prescaler restart from 0.
- R5: Control bits [15:8] (address 5) hold a two's-complement trim N. Each enabled cycle adds |N| to an accumulator. Whenever the accumulator reaches 1,000,000, it drops by 1,000,000 and one timebase step is corrected. For positive N the prescaler advances by 2 instead of 1, so the clock runs faster. For negative N it advances by 0, so the clock runs slower. Loading the seconds count clears the accumulator.
- R6: A write to address 2 sets the seconds-match compare value and arms that alarm. When an increment makes the seconds count equal the compare value, the alarm fires. It sets flag bit 0 if control bit 0 is set. With control bit 1 set, the compare value then grows by the interval at address 3 and the alarm stays armed. Otherwise the alarm disarms.
- R7: A nonzero write V to address 4 arms the countdown alarm. The alarm fires on the V-th following fraction step. It sets flag bit 1 only if control bit 2 is set. With control bit 3 set, it reloads V and keeps running. Otherwise it disarms. When control bit 2 is clear, firing leaves the flag at 0.
- R8: The flags (address 6: bit 0 seconds-match, bit 1 countdown) stay set until software writes 1 to the matching bit at address 6. `irqTod` and `irqSub` follow the flags, and `wakeReq` is their OR.
- R9: Addresses 2, 3, 4 and 5 read back the current compare value, the seconds interval, the countdown interval and the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tbEn | input | 1 | One-cycle enable per 32.768 kHz timebase period |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data, combinational |
| irqTod | output | 1 | Seconds-match alarm request |
| irqSub | output | 1 | Countdown alarm request |
| wakeReq | output | 1 | Either request |

## Verification
The trim correction is the hardest case to reach from the ports. At the maximum trim, one correction happens only every 7,874 timebase cycles, and a correction is only visible when it moves a fraction step across a boundary. The stimulus loads the seconds count so the prescaler and accumulator restart at a known point. It then runs a cycle count chosen so that exactly two corrections move the fraction count by one step either way. The alarm tests first stop the timebase, so the countdown phase is known. They then run to one cycle before and one cycle after each firing point.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_SEC    = 3'd0;
  localparam logic [ADDR_W-1:0] A_SUB    = 3'd1;
  localparam logic [ADDR_W-1:0] A_TODCMP = 3'd2;
  localparam logic [ADDR_W-1:0] A_TODIVL = 3'd3;
  localparam logic [ADDR_W-1:0] A_SUBIVL = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd6;

  typedef struct packed {
    logic secLoad;
    logic subTick;
    logic todArm;
    logic subArm;
    logic clrTod;
    logic clrSub;
  } rtc_strobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int SEC_W     = 32,
  parameter int SUB_W     = 12,
  parameter int PRE_DIV   = 8,
  parameter int TRIM_W    = 8,
  parameter int PPM_SCALE = 1000000,
  parameter int TIV_W     = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tbEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SEC_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [SEC_W-1:0]  rdData,
  input  logic [SEC_W-1:0]  secCnt,
  input  logic [SUB_W-1:0]  subCnt,
  input  logic [SEC_W-1:0]  todCmp,
  input  logic              todFlag,
  input  logic              subFlag,
  output rtc_strobe_t       stb,
  output logic [SEC_W-1:0]  secPendVal,
  output logic [TIV_W-1:0]  todIvl,
  output logic [SUB_W:0]    subIvl,
  output logic              todEn,
  output logic              todRecur,
  output logic              subEn,
  output logic              subRecur
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int ACC_W = $clog2(PPM_SCALE) + 1;

  logic              pendLoad;
  logic [PRE_W-1:0]  preCnt;
  logic [ACC_W-1:0]  trimAcc;
  logic [TRIM_W-1:0] trimVal;
  logic [TRIM_W-1:0] trimMag;
  logic [ACC_W-1:0]  accSum;
  logic              trimEvt;
  logic [PRE_W+1:0]  preStep;
  logic [PRE_W+1:0]  preSum;
  logic              preCarry;
  logic [PRE_W-1:0]  preNext;
  logic [SEC_W-1:0]  ctrlWord;

  assign trimMag  = trimVal[TRIM_W-1] ? (~trimVal + 1'b1) : trimVal;
  assign accSum   = trimAcc + ACC_W'(trimMag);
  assign trimEvt  = (trimMag != '0) && (accSum >= ACC_W'(PPM_SCALE));

  always_comb begin
    if (!trimEvt)                preStep = (PRE_W+2)'(1);
    else if (trimVal[TRIM_W-1])  preStep = '0;
    else                         preStep = (PRE_W+2)'(2);
    preSum   = (PRE_W+2)'(preCnt) + preStep;
    preCarry = preSum >= (PRE_W+2)'(PRE_DIV);
    preNext  = preCarry ? PRE_W'(preSum - (PRE_W+2)'(PRE_DIV)) : PRE_W'(preSum);
  end

  always_comb begin
    stb.secLoad = tbEn && pendLoad;
    stb.subTick = tbEn && !pendLoad && preCarry;
    stb.todArm  = wrEn && (wrAddr == A_TODCMP);
    stb.subArm  = wrEn && (wrAddr == A_SUBIVL);
    stb.clrTod  = wrEn && (wrAddr == A_FLAGS) && wrData[0];
    stb.clrSub  = wrEn && (wrAddr == A_FLAGS) && wrData[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      trimAcc <= '0;
    end else if (stb.secLoad) begin
      preCnt  <= '0;
      trimAcc <= '0;
    end else if (tbEn) begin
      preCnt  <= preNext;
      trimAcc <= trimEvt ? accSum - ACC_W'(PPM_SCALE) : accSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLoad   <= 1'b0;
      secPendVal <= '0;
      todIvl     <= '0;
      subIvl     <= '0;
      trimVal    <= '0;
      todEn      <= 1'b0;
      todRecur   <= 1'b0;
      subEn      <= 1'b0;
      subRecur   <= 1'b0;
    end else begin
      if (stb.secLoad) pendLoad <= 1'b0;
      if (wrEn) begin
        case (wrAddr)
          A_SEC: begin
            pendLoad   <= 1'b1;
            secPendVal <= wrData;
          end
          A_TODIVL: todIvl <= wrData[TIV_W-1:0];
          A_SUBIVL: subIvl <= wrData[SUB_W:0];
          A_CTRL: begin
            todEn    <= wrData[0];
            todRecur <= wrData[1];
            subEn    <= wrData[2];
            subRecur <= wrData[3];
            trimVal  <= wrData[TRIM_W+7:8];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctrlWord             = '0;
    ctrlWord[3:0]        = {subRecur, subEn, todRecur, todEn};
    ctrlWord[TRIM_W+7:8] = trimVal;
  end

  always_comb begin
    case (rdAddr)
      A_SEC:    rdData = secCnt;
      A_SUB:    rdData = SEC_W'(subCnt);
      A_TODCMP: rdData = todCmp;
      A_TODIVL: rdData = SEC_W'(todIvl);
      A_SUBIVL: rdData = SEC_W'(subIvl);
      A_CTRL:   rdData = ctrlWord;
      A_FLAGS:  rdData = SEC_W'({subFlag, todFlag});
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_dp.sv
module rtc_dp
  import rtc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 12,
  parameter int TIV_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtc_strobe_t      stb,
  input  logic [SEC_W-1:0] secPendVal,
  input  logic [SEC_W-1:0] wrData,
  input  logic [TIV_W-1:0] todIvl,
  input  logic [SUB_W:0]   subIvl,
  input  logic             todEn,
  input  logic             todRecur,
  input  logic             subEn,
  input  logic             subRecur,
  output logic [SEC_W-1:0] secCnt,
  output logic [SUB_W-1:0] subCnt,
  output logic [SEC_W-1:0] todCmp,
  output logic             todFlag,
  output logic             subFlag
);
  logic             secInc;
  logic [SEC_W-1:0] secNext;
  logic             todArmed;
  logic             todHit;
  logic [SUB_W:0]   subDown;
  logic             subArmed;
  logic             subHit;

  assign secInc  = stb.subTick && (&subCnt);
  assign secNext = secCnt + 1'b1;
  assign todHit  = todArmed && secInc && (secNext == todCmp);
  assign subHit  = subArmed && stb.subTick && (subDown == (SUB_W+1)'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCnt <= '0;
      subCnt <= '0;
    end else if (stb.secLoad) begin
      secCnt <= secPendVal;
      subCnt <= '0;
    end else if (stb.subTick) begin
      subCnt <= subCnt + 1'b1;
      if (secInc) secCnt <= secNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      todCmp   <= '0;
      todArmed <= 1'b0;
    end else if (stb.todArm) begin
      todCmp   <= wrData;
      todArmed <= 1'b1;
    end else if (todHit) begin
      if (todRecur) todCmp <= todCmp + SEC_W'(todIvl);
      else          todArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subDown  <= '0;
      subArmed <= 1'b0;
    end else if (stb.subArm) begin
      subDown  <= wrData[SUB_W:0];
      subArmed <= |wrData[SUB_W:0];
    end else if (subArmed && stb.subTick) begin
      if (subHit) begin
        if (subRecur) subDown <= subIvl;
        else          subArmed <= 1'b0;
      end else begin
        subDown <= subDown - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      todFlag <= 1'b0;
      subFlag <= 1'b0;
    end else begin
      if (todHit && todEn) todFlag <= 1'b1;
      else if (stb.clrTod) todFlag <= 1'b0;
      if (subHit && subEn) subFlag <= 1'b1;
      else if (stb.clrSub) subFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
#(
  parameter int SEC_W     = 32,
  parameter int SUB_W     = 12,
  parameter int PRE_DIV   = 8,
  parameter int TRIM_W    = 8,
  parameter int PPM_SCALE = 1000000,
  parameter int TIV_W     = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tbEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SEC_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [SEC_W-1:0]  rdData,
  output logic              irqTod,
  output logic              irqSub,
  output logic              wakeReq
);
  rtc_strobe_t      stb;
  logic [SEC_W-1:0] secPendVal;
  logic [TIV_W-1:0] todIvl;
  logic [SUB_W:0]   subIvl;
  logic             todEn, todRecur, subEn, subRecur;
  logic [SEC_W-1:0] secCnt;
  logic [SUB_W-1:0] subCnt;
  logic [SEC_W-1:0] todCmp;
  logic             todFlag, subFlag;

  rtc_ctrl #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .PRE_DIV(PRE_DIV),
    .TRIM_W(TRIM_W), .PPM_SCALE(PPM_SCALE), .TIV_W(TIV_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tbEn(tbEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .secCnt(secCnt), .subCnt(subCnt), .todCmp(todCmp),
    .todFlag(todFlag), .subFlag(subFlag),
    .stb(stb), .secPendVal(secPendVal), .todIvl(todIvl), .subIvl(subIvl),
    .todEn(todEn), .todRecur(todRecur), .subEn(subEn), .subRecur(subRecur)
  );

  rtc_dp #(.SEC_W(SEC_W), .SUB_W(SUB_W), .TIV_W(TIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .secPendVal(secPendVal), .wrData(wrData),
    .todIvl(todIvl), .subIvl(subIvl),
    .todEn(todEn), .todRecur(todRecur), .subEn(subEn), .subRecur(subRecur),
    .secCnt(secCnt), .subCnt(subCnt), .todCmp(todCmp),
    .todFlag(todFlag), .subFlag(subFlag)
  );

  assign irqTod  = todFlag;
  assign irqSub  = subFlag;
  assign wakeReq = todFlag || subFlag;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              tbEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [SEC_W-1:0]  wrData,
  input logic [SEC_W-1:0]  secCnt,
  input logic [SUB_W-1:0]  subCnt,
  input logic [SEC_W-1:0]  secPendVal,
  input logic              secLoad,
  input logic              subTick,
  input logic              todFlag,
  input logic              subFlag
);
  a_r1_hold_without_timebase: assert property (@(posedge clk) disable iff (!rstN)
    !tbEn |=> $stable(secCnt) && $stable(subCnt));

  // R2 and R3: a fraction wrap carries into the seconds count, including its rollover
  a_r2_fraction_carry: assert property (@(posedge clk) disable iff (!rstN)
    (subTick && (&subCnt)) |=> (secCnt == $past(secCnt) + 1'b1) && (subCnt == '0));

  a_r4_deferred_load: assert property (@(posedge clk) disable iff (!rstN)
    secLoad |=> (secCnt == $past(secPendVal)) && (subCnt == '0));

  a_r8_tod_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (todFlag && !(wrEn && (wrAddr == A_FLAGS) && wrData[0])) |=> todFlag);

  a_r8_sub_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (subFlag && !(wrEn && (wrAddr == A_FLAGS) && wrData[1])) |=> subFlag);

  a_r7_sub_flag_on_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(subFlag) |-> $past(subTick));
endmodule

bind rtc_top rtc_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rstN(rstN), .tbEn(tbEn),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .secCnt(secCnt), .subCnt(subCnt), .secPendVal(secPendVal),
  .secLoad(stb.secLoad), .subTick(stb.subTick),
  .todFlag(todFlag), .subFlag(subFlag)
);

// File: tb/tb_rtc_top.sv
module tb_rtc_top;
  import rtc_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tbEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqTod, irqSub, wakeReq;
  int nErr = 0;
  int nChk = 0;

  always #5 clk = ~clk;

  rtc_top dut (
    .clk(clk), .rstN(rstN), .tbEn(tbEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .irqTod(irqTod), .irqSub(irqSub), .wakeReq(wakeReq)
  );

  typedef struct packed {
    logic [7:0]  trim;
    logic [31:0] start;
    logic [31:0] edges;
    logic [31:0] expSec;
    logic [31:0] expSub;
  } vec_t;

  // rows 0-1: R2 wrap and R3 rollover; row 2: R2 rate; rows 3-4: R5 trim both signs
  localparam vec_t VECS [5] = '{
    '{8'h00, 32'hFFFF_FFFF, 32'd32767, 32'hFFFF_FFFF, 32'd4095},
    '{8'h00, 32'hFFFF_FFFF, 32'd32768, 32'h0000_0000, 32'd0},
    '{8'h00, 32'd7,         32'd15998, 32'd7,         32'd1999},
    '{8'h7F, 32'd7,         32'd15998, 32'd7,         32'd2000},
    '{8'h81, 32'd7,         32'd16000, 32'd7,         32'd1999}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic runEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // load seconds with the timebase running, then freeze it at a known phase
  task automatic loadAndFreeze(input logic [31:0] s);
    tbEn = 1'b1;
    wr(A_SEC, s);
    runEdges(1);
    tbEn = 1'b0;
  endtask

  task automatic subScenario(input logic [31:0] ctrl, input bit expFire, input bit recur,
                             input string tag);
    logic [31:0] v;
    loadAndFreeze(32'd0);
    wr(A_CTRL, ctrl);
    wr(A_FLAGS, 32'h3);
    wr(A_SUBIVL, 32'd3);
    tbEn = 1'b1;
    runEdges(23);
    rd(A_FLAGS, v); check({tag, " before third step"}, v, 32'h0);
    runEdges(1);
    rd(A_FLAGS, v); check({tag, " at third step"}, v, expFire ? 32'h2 : 32'h0);
    check({tag, " irqSub"}, {31'b0, irqSub}, {31'b0, expFire});
    tbEn = 1'b0;
    wr(A_FLAGS, 32'h2);
    tbEn = 1'b1;
    runEdges(23);
    rd(A_FLAGS, v); check({tag, " second period early"}, v, 32'h0);
    runEdges(1);
    rd(A_FLAGS, v); check({tag, " second period"}, v, (expFire && recur) ? 32'h2 : 32'h0);
    tbEn = 1'b0;
    wr(A_FLAGS, 32'h3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and hold with timebase off
    rd(A_SEC, v);   check("R1 reset seconds", v, 32'h0);
    rd(A_SUB, v);   check("R1 reset fraction", v, 32'h0);
    rd(A_FLAGS, v); check("R1 reset flags", v, 32'h0);
    check("R1 reset requests", {29'b0, irqTod, irqSub, wakeReq}, 32'h0);
    runEdges(40);
    rd(A_SUB, v);   check("R1 no step without timebase", v, 32'h0);

    // R4 deferred seconds load
    wr(A_SEC, 32'd5);
    rd(A_SEC, v);   check("R4 seconds unchanged before timebase", v, 32'h0);
    tbEn = 1'b1;
    runEdges(20);
    tbEn = 1'b0;
    rd(A_SEC, v);   check("R4 seconds loaded", v, 32'd5);
    rd(A_SUB, v);   check("R4 fraction after load", v, 32'd2);

    // R9 readback
    wr(A_CTRL, 32'h0000_7F0A);
    rd(A_CTRL, v);  check("R9 control readback", v, 32'h0000_7F0A);
    wr(A_TODIVL, 32'h000A_BCDE);
    rd(A_TODIVL, v); check("R9 interval readback", v, 32'h000A_BCDE);
    wr(A_SUBIVL, 32'd4096);
    rd(A_SUBIVL, v); check("R9 countdown readback", v, 32'd4096);

    // vector table: R2 R3 R5
    for (int i = 0; i < 5; i++) begin
      tbEn = 1'b1;
      wr(A_CTRL, {16'h0, VECS[i].trim, 8'h0});
      wr(A_SEC, VECS[i].start);
      runEdges(1);
      runEdges(int'(VECS[i].edges));
      tbEn = 1'b0;
      rd(A_SEC, v); check($sformatf("R2 R3 R5 row %0d seconds", i), v, VECS[i].expSec);
      rd(A_SUB, v); check($sformatf("R2 R3 R5 row %0d fraction", i), v, VECS[i].expSub);
    end

    // R7 countdown alarm: recurring, one-shot, disabled
    subScenario(32'h0000_000C, 1'b1, 1'b1, "R7 recurring");
    subScenario(32'h0000_0004, 1'b1, 1'b0, "R7 one-shot");
    subScenario(32'h0000_0000, 1'b0, 1'b0, "R7 disabled");

    // R6 seconds-match alarm, recurring, interval 1
    wr(A_CTRL, 32'h0000_0003);
    loadAndFreeze(32'd100);
    wr(A_TODIVL, 32'd1);
    wr(A_TODCMP, 32'd101);
    tbEn = 1'b1;
    runEdges(32767);
    rd(A_FLAGS, v); check("R6 no match before second", v, 32'h0);
    runEdges(1);
    tbEn = 1'b0;
    rd(A_SEC, v);    check("R6 seconds at match", v, 32'd101);
    rd(A_FLAGS, v);  check("R6 flag at match", v, 32'h1);
    rd(A_TODCMP, v); check("R6 compare advanced", v, 32'd102);
    check("R8 irqTod and wakeReq", {30'b0, irqTod, wakeReq}, 32'h3);

    // R8 write-one clear, bit 1 write leaves bit 0 alone
    wr(A_FLAGS, 32'h2);
    rd(A_FLAGS, v); check("R8 clear of other bit ignored", v, 32'h1);
    wr(A_FLAGS, 32'h1);
    rd(A_FLAGS, v); check("R8 flag cleared", v, 32'h0);
    check("R8 wakeReq low", {31'b0, wakeReq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule